// File: doc/BRIEF.md
# Front-Panel Memory Loader

This block lets an operator fill a small RAM one byte at a time from panel switches and push buttons. It holds a 7-bit address pointer and accepts three debounced single-cycle pulses: clear, which sends the pointer back to zero; step, which stores the data switch value at the pointer and then moves on; and skip, which moves on without storing. It drives a RAM write port and shows the pointer on a display output.

The block only acts while a two-bit mode selector reads "set". In the run and step modes, and in the spare code, every pulse is dropped. A step pulse is registered first. In the following cycle the write strobe is high with the captured data and the current pointer on the address port. The pointer advances on the edge that closes that write cycle, so back-to-back steps land in consecutive cells.

Top module: `memld_panel_loader`

## Requirements
- R1: The mode code 2'b10 selects set mode. 2'b00 (run), 2'b01 (step) and 2'b11 (spare) are inactive: pulses in those modes cause no write and leave the pointer unchanged.
- R2: A clear pulse in set mode makes the pointer 0 on the next edge. It overrides a step or skip in the same cycle and any advance still pending from a write.
- R3: A step pulse in set mode (without clear) raises `ram_we` for exactly one cycle, the cycle after the pulse. During that cycle `ram_wdata` equals the switch value sampled with the pulse and `ram_addr` equals the pointer.
- R4: The pointer increments by one on the edge that ends the write cycle. During the write cycle it still holds the written address.
- R5: A skip pulse in set mode increments the pointer on the next edge and never raises `ram_we`.
- R6: When step and skip arrive in the same cycle, only the step takes effect: one write, and the pointer advances by one.
- R7: The pointer is 7 bits wide and wraps from 0x7F to 0x00. Bit 7 of `ram_addr` is always 0, so only addresses 0x00 to 0x7F are written.
- R8: After reset the pointer is 0 and `ram_we` is low.
- R9: A step or skip accepted during a write cycle adds its advance to the pending one. Steps on consecutive cycles write consecutive cells, and a skip in a write cycle moves the pointer by two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 2 | Machine mode: 00 run, 01 step, 10 set, 11 spare |
| pls_clear | input | 1 | Single-cycle pulse: return the pointer to zero |
| pls_step | input | 1 | Single-cycle pulse: store the switch value and advance |
| pls_skip | input | 1 | Single-cycle pulse: advance without storing |
| sw_data | input | 8 | Data switch value |
| ram_addr | output | 8 | RAM write address |
| ram_wdata | output | 8 | RAM write data |
| ram_we | output | 1 | RAM write enable |
| disp_ptr | output | 7 | Current pointer, for display |

## Verification
A wrong pointer shows up on `disp_ptr` one edge after the pulse that moved it. It also shows on `ram_addr` during the next write, and in the data read back from the bench memory after a full sweep. A stray or doubled write strobe overwrites a cell whose expected value the bench knows, so it appears at the read-back. A missing write leaves a stale value in the same way. Wrong mode gating or pulse priority shows within one or two cycles as a pointer that moved when it should have held, or as a write in an inactive mode.

// File: rtl/memld_pkg.sv
package memld_pkg;
  typedef enum logic [1:0] {
    MODE_RUN  = 2'b00,
    MODE_STEP = 2'b01,
    MODE_SET  = 2'b10,
    MODE_RSVD = 2'b11
  } panel_mode_e;

  typedef struct packed {
    logic clr;
    logic wr;
    logic adv;
  } panel_cmd_t;
endpackage

// File: rtl/memld_gate.sv
module memld_gate
  import memld_pkg::*;
(
  input  logic [1:0] mode_sel,
  input  logic       pls_clear,
  input  logic       pls_step,
  input  logic       pls_skip,
  output panel_cmd_t cmd
);
  logic set_mode;

  always_comb begin
    set_mode = (mode_sel == MODE_SET);
    cmd.clr  = set_mode & pls_clear;
    cmd.wr   = set_mode & pls_step & ~pls_clear;
    cmd.adv  = set_mode & pls_skip & ~pls_step & ~pls_clear;
  end
endmodule

// File: rtl/memld_strobe.sv
module memld_strobe #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_req,
  input  logic [DATA_W-1:0] sw_data,
  output logic              we_o,
  output logic [DATA_W-1:0] wdata_o
);
  logic              we_d;
  logic [DATA_W-1:0] wdata_d;
  logic              wdata_en;

  always_comb begin
    we_d     = wr_req;
    wdata_en = wr_req;
    wdata_d  = sw_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_o <= 1'b0;
    end else begin
      we_o <= we_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wdata_o <= '0;
    end else if (wdata_en) begin
      wdata_o <= wdata_d;
    end
  end
endmodule

// File: rtl/memld_ptr.sv
module memld_ptr #(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              adv_skip,
  input  logic              adv_write,
  output logic [ADDR_W-1:0] ptr_o
);
  logic [ADDR_W-1:0] ptr_d;
  logic [ADDR_W-1:0] inc_amt;
  logic              ptr_en;

  always_comb begin
    inc_amt = ADDR_W'(adv_skip) + ADDR_W'(adv_write);
    ptr_en  = clr | adv_skip | adv_write;
    if (clr) begin
      ptr_d = '0;
    end else begin
      ptr_d = ptr_o + inc_amt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_o <= '0;
    end else if (ptr_en) begin
      ptr_o <= ptr_d;
    end
  end
endmodule

// File: rtl/memld_panel_loader.sv
module memld_panel_loader
  import memld_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int BUS_AW = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode_sel,
  input  logic              pls_clear,
  input  logic              pls_step,
  input  logic              pls_skip,
  input  logic [DATA_W-1:0] sw_data,
  output logic [BUS_AW-1:0] ram_addr,
  output logic [DATA_W-1:0] ram_wdata,
  output logic              ram_we,
  output logic [ADDR_W-1:0] disp_ptr
);
  localparam int PAD_W = BUS_AW - ADDR_W;

  panel_cmd_t        cmd;
  logic [ADDR_W-1:0] ptr;

  memld_gate u_gate (
    .mode_sel  (mode_sel),
    .pls_clear (pls_clear),
    .pls_step  (pls_step),
    .pls_skip  (pls_skip),
    .cmd       (cmd)
  );

  memld_strobe #(.DATA_W(DATA_W)) u_strobe (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_req  (cmd.wr),
    .sw_data (sw_data),
    .we_o    (ram_we),
    .wdata_o (ram_wdata)
  );

  memld_ptr #(.ADDR_W(ADDR_W)) u_ptr (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (cmd.clr),
    .adv_skip  (cmd.adv),
    .adv_write (ram_we),
    .ptr_o     (ptr)
  );

  generate
    if (PAD_W > 0) begin : g_pad
      assign ram_addr = {{PAD_W{1'b0}}, ptr};
    end else begin : g_nopad
      assign ram_addr = ptr[BUS_AW-1:0];
    end
  endgenerate

  assign disp_ptr = ptr;
endmodule

// File: rtl/memld_panel_loader_chk.sv
module memld_panel_loader_chk #(
  parameter int ADDR_W = 7,
  parameter int BUS_AW = 8,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        mode_sel,
  input logic              pls_clear,
  input logic              pls_step,
  input logic              pls_skip,
  input logic [DATA_W-1:0] sw_data,
  input logic [BUS_AW-1:0] ram_addr,
  input logic [DATA_W-1:0] ram_wdata,
  input logic              ram_we,
  input logic [ADDR_W-1:0] disp_ptr
);
  logic in_set;
  assign in_set = (mode_sel == 2'b10);

  // R1
  idle_mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_set && !ram_we) |=> ($stable(disp_ptr) && !ram_we));

  // R2
  clear_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_set && pls_clear) |=> (disp_ptr == '0));

  // R3
  step_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_set && pls_step && !pls_clear) |=>
      (ram_we && ram_wdata == $past(sw_data) && ram_addr[ADDR_W-1:0] == disp_ptr));

  // R4
  write_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we && !(in_set && (pls_clear || (pls_skip && !pls_step)))) |=>
      (disp_ptr == ADDR_W'($past(disp_ptr) + 1'b1)));

  // R5
  skip_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_set && pls_skip && !pls_step && !pls_clear && !ram_we) |=>
      (disp_ptr == ADDR_W'($past(disp_ptr) + 1'b1) && !ram_we));
endmodule

bind memld_panel_loader memld_panel_loader_chk #(
  .ADDR_W(ADDR_W), .BUS_AW(BUS_AW), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .pls_clear(pls_clear),
  .pls_step(pls_step), .pls_skip(pls_skip), .sw_data(sw_data),
  .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_we(ram_we),
  .disp_ptr(disp_ptr)
);

// File: tb/memld_panel_loader_tb.sv
module memld_panel_loader_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode_sel = 2'b10;
  logic       pls_clear = 1'b0;
  logic       pls_step = 1'b0;
  logic       pls_skip = 1'b0;
  logic [7:0] sw_data = 8'h00;
  logic [7:0] ram_addr;
  logic [7:0] ram_wdata;
  logic       ram_we;
  logic [6:0] disp_ptr;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [7:0] mem [128];

  always #4 clk = ~clk;

  memld_panel_loader u_dut (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .pls_clear(pls_clear),
    .pls_step(pls_step), .pls_skip(pls_skip), .sw_data(sw_data),
    .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_we(ram_we),
    .disp_ptr(disp_ptr)
  );

  always @(posedge clk) if (ram_we) mem[ram_addr[6:0]] <= ram_wdata;

  function automatic logic [7:0] pat(int i, int salt);
    return 8'((i * 37 + salt * 11 + 5) % 256);
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_step(logic [7:0] val, int exp_ptr);
    @(negedge clk); sw_data = val; pls_step = 1'b1;
    @(negedge clk); pls_step = 1'b0; sw_data = ~val;
    chk(ram_we == 1'b1, "R3", "we", int'(ram_we), 1);
    chk(ram_wdata == val, "R3", "wdata", int'(ram_wdata), int'(val));
    chk(ram_addr == 8'(exp_ptr), "R7", "addr", int'(ram_addr), exp_ptr);
    chk(disp_ptr == 7'(exp_ptr), "R4", "ptr held in write cycle", int'(disp_ptr), exp_ptr);
    @(negedge clk);
    chk(ram_we == 1'b0, "R3", "we one cycle", int'(ram_we), 0);
    chk(disp_ptr == 7'((exp_ptr + 1) % 128), "R4", "ptr after write",
        int'(disp_ptr), (exp_ptr + 1) % 128);
  endtask

  task automatic do_skip(int exp_ptr);
    @(negedge clk); pls_skip = 1'b1;
    @(negedge clk); pls_skip = 1'b0;
    chk(ram_we == 1'b0, "R5", "no write on skip", int'(ram_we), 0);
    chk(disp_ptr == 7'((exp_ptr + 1) % 128), "R5", "skip advance",
        int'(disp_ptr), (exp_ptr + 1) % 128);
  endtask

  task automatic do_clear();
    @(negedge clk); pls_clear = 1'b1;
    @(negedge clk); pls_clear = 1'b0;
    chk(disp_ptr == 7'd0, "R2", "clear", int'(disp_ptr), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(disp_ptr == 7'd0, "R8", "reset ptr", int'(disp_ptr), 0);
    chk(ram_we == 1'b0, "R8", "reset we", int'(ram_we), 0);

    // Full fill sweep, then wrap (R3, R4, R7)
    for (int i = 0; i < 128; i++) do_step(pat(i, 0), i);
    chk(disp_ptr == 7'd0, "R7", "wrap to zero", int'(disp_ptr), 0);
    for (int i = 0; i < 128; i++)
      chk(mem[i] == pat(i, 0), "R3", "readback", int'(mem[i]), int'(pat(i, 0)));

    // Skip sweep over the whole range, memory untouched (R5, R7)
    for (int i = 0; i < 128; i++) do_skip(i);
    chk(disp_ptr == 7'd0, "R7", "skip wrap", int'(disp_ptr), 0);
    for (int i = 0; i < 128; i++)
      chk(mem[i] == pat(i, 0), "R5", "skip leaves memory", int'(mem[i]), int'(pat(i, 0)));

    // Clear from several positions (R2)
    for (int n = 1; n < 128; n += 21) begin
      for (int k = 0; k < n; k++) do_skip(k);
      do_clear();
    end

    // Inactive modes ignore every pulse (R1)
    for (int k = 0; k < 9; k++) do_skip(k);
    for (int m = 0; m < 4; m++) begin
      if (m == 2) continue;
      for (int p = 0; p < 3; p++) begin
        @(negedge clk);
        mode_sel = 2'(m);
        sw_data = 8'hA5;
        pls_step = (p == 0); pls_skip = (p == 1); pls_clear = (p == 2);
        @(negedge clk);
        pls_step = 1'b0; pls_skip = 1'b0; pls_clear = 1'b0;
        chk(ram_we == 1'b0, "R1", "no write in inactive mode", int'(ram_we), 0);
        chk(disp_ptr == 7'd9, "R1", "ptr held in inactive mode", int'(disp_ptr), 9);
        @(negedge clk);
        chk(ram_we == 1'b0 && disp_ptr == 7'd9, "R1", "ptr held later", int'(disp_ptr), 9);
      end
    end
    @(negedge clk); mode_sel = 2'b10;
    chk(mem[9] == pat(9, 0), "R1", "cell untouched", int'(mem[9]), int'(pat(9, 0)));

    // Step and skip together: step wins (R6)
    @(negedge clk); sw_data = 8'h3C; pls_step = 1'b1; pls_skip = 1'b1;
    @(negedge clk); pls_step = 1'b0; pls_skip = 1'b0;
    chk(ram_we == 1'b1 && ram_addr == 8'd9, "R6", "step wins write", int'(ram_addr), 9);
    @(negedge clk);
    chk(disp_ptr == 7'd10, "R6", "advance by one", int'(disp_ptr), 10);
    chk(mem[9] == 8'h3C, "R6", "cell written", int'(mem[9]), 'h3C);

    // Back-to-back steps (R9)
    @(negedge clk); sw_data = 8'h11; pls_step = 1'b1;
    @(negedge clk); sw_data = 8'h22;
    chk(ram_addr == 8'd10 && ram_wdata == 8'h11, "R9", "first write", int'(ram_addr), 10);
    @(negedge clk); pls_step = 1'b0;
    chk(ram_we == 1'b1 && ram_addr == 8'd11, "R9", "second write", int'(ram_addr), 11);
    @(negedge clk);
    chk(disp_ptr == 7'd12, "R9", "ptr after pair", int'(disp_ptr), 12);
    chk(mem[10] == 8'h11 && mem[11] == 8'h22, "R9", "pair data", int'(mem[11]), 'h22);

    // Skip inside a write cycle: advance by two (R9)
    @(negedge clk); sw_data = 8'h5A; pls_step = 1'b1;
    @(negedge clk); pls_step = 1'b0; pls_skip = 1'b1;
    @(negedge clk); pls_skip = 1'b0;
    chk(disp_ptr == 7'd14, "R9", "skip during write", int'(disp_ptr), 14);
    chk(mem[12] == 8'h5A && mem[13] == pat(13, 0), "R9", "skip cell kept", int'(mem[13]), int'(pat(13, 0)));

    // Clear during a write cycle: write lands, pointer zero (R2)
    @(negedge clk); sw_data = 8'h77; pls_step = 1'b1;
    @(negedge clk); pls_step = 1'b0; pls_clear = 1'b1;
    @(negedge clk); pls_clear = 1'b0;
    chk(disp_ptr == 7'd0, "R2", "clear beats pending advance", int'(disp_ptr), 0);
    chk(mem[14] == 8'h77, "R2", "pending write kept", int'(mem[14]), 'h77);

    // Clear with step in same cycle: no write (R2)
    do_skip(0);
    @(negedge clk); pls_clear = 1'b1; pls_step = 1'b1; sw_data = 8'hEE;
    @(negedge clk); pls_clear = 1'b0; pls_step = 1'b0;
    chk(ram_we == 1'b0 && disp_ptr == 7'd0, "R2", "clear over step", int'(disp_ptr), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule